// File: doc/BRIEF.md
# Flash Rewrite Controller with Erase Suspend

This block lets the CPU program and erase an on-chip flash array through a small register interface. One writable control register holds a rewrite-enable bit, a rewrite-mode bit, a suspend-enable bit and a suspend-request bit. A read-only status view shows the ready/busy flag, the array-read-enable flag and the status-read path select. Program and block-erase commands come in on a separate strobe. A parameterised down-counter stands in for the flash operation's duration.

An erase can be paused part-way through, and array reads are allowed while it is paused. Software pauses it by writing the suspend-request bit. In the interrupt-driven mode, a pending interrupt pauses it automatically. An interrupt is honoured only after a fixed latency window that starts at the erase command. Clearing the request resumes the erase, and the counter continues from the count it held when it stopped.

Top module: `flash_rw_ctrl`

## Requirements
- R1: After reset, the control readback (`rd_sel`=0) is 0x00. The status readback (`rd_sel`=1) is 0x03. The status layout is bit0 ready, bit1 array-read-enable, bit2 status-path select.
- R2: While the rewrite-enable bit (control bit0) is 0, program (`cmd_code`=1), erase (2) and read-status (3) commands have no effect.
- R3: The rewrite-mode bit (control bit1) becomes 1 only if the rewrite-enable bit already reads 1 before the write. Writing it to 0 always clears it.
- R4: A write that clears rewrite-enable while an operation is busy is dropped. The same write is honoured when ready is 1.
- R5: An accepted program or erase drives ready to 0 from the next cycle. Ready stays 0 for exactly PROG_CYC or ERASE_CYC cycles. Commands that arrive while busy are ignored.
- R6: Writing 1 to the suspend-request bit (control bit3) during an armed erase sets the bit. From the next cycle the counter freezes, array-read-enable goes to 1 and ready stays 0.
- R7: Writing 0 to the suspend-request bit resumes the erase. Ready returns after ERASE_CYC cycles plus the number of paused cycles.
- R8: An erase is armed only if the suspend-enable bit (control bit2) was 1 when the erase was accepted. Otherwise a suspend write is dropped: the bit reads 0 and the erase ends on time.
- R9: In rewrite mode 1, `irq_req` pauses an armed erase and sets the suspend-request bit. It is sampled first at the (SUSP_LAT+1)-th edge after the acceptance edge. An earlier `irq_req` is ignored.
- R10: In rewrite mode 0, `irq_req` has no effect on an erase.
- R11: In mode 0, an accepted read-status command sets the status-path select. The next accepted program or erase clears it. In mode 1, the read-status command is ignored.
- R12: A suspend request, from software or from an interrupt, that lands on the clock edge where the erase count ends is dropped. The erase completes and the suspend-request bit reads 0.
- R13: Array-read-enable is 0 exactly while an operation is busy and not paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control write data (bit0 enable, bit1 mode, bit2 suspend-enable, bit3 suspend-request) |
| rd_sel | input | 1 | Readback select: 0 control, 1 status |
| reg_rdata | output | 8 | Readback data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 1 program, 2 block erase, 3 read status |
| irq_req | input | 1 | Enabled interrupt request |
| flash_ready | output | 1 | 1 when no operation is busy |
| array_rd_en | output | 1 | User array may be read |
| stat_path_sel | output | 1 | Array reads return status instead of data |

## Verification
Two collisions are provoked on the edge where an erase count runs out: a software write of the suspend-request bit, and an interrupt in mode 1. Both requests must be dropped, so the check is that ready is 1 and the suspend-request bit is 0 one cycle later. The latency boundary is tested by holding the interrupt high across the last blocked edge and the first open edge. The suspend must take effect exactly one cycle after the open edge. Busy lengths with pauses are judged against the nominal count plus the number of paused cycles.

// File: rtl/flash_rw_pkg.sv
package flash_rw_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_PROG   = 2'd1,
        CMD_ERASE  = 2'd2,
        CMD_RDSTAT = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    // bit0 rewrite enable, bit1 mode, bit2 suspend enable, bit3 suspend request
    typedef struct packed {
        logic susp_req;
        logic susp_en;
        logic mode1;
        logic rw_en;
    } ctrl_t;

    typedef struct packed {
        logic stat_sel;
        logic rd_en;
        logic ready;
    } stat_t;

    function automatic logic [7:0] pack_ctrl(ctrl_t c);
        return {4'b0000, c};
    endfunction

    function automatic logic [7:0] pack_stat(stat_t s);
        return {5'b00000, s};
    endfunction

    function automatic int cnt_width(int maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/frw_ctrl_regs.sv
module frw_ctrl_regs
    import flash_rw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ctrl_t wdata,
    input  logic  ready,
    output logic  rw_en,
    output logic  mode1,
    output logic  susp_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rw_en   <= 1'b0;
            mode1   <= 1'b0;
            susp_en <= 1'b0;
        end else if (we) begin
            susp_en <= wdata.susp_en;
            // enable sets freely; clearing waits for an idle engine
            if (wdata.rw_en)
                rw_en <= 1'b1;
            else if (ready)
                rw_en <= 1'b0;
            // mode 1 needs the enable bit already set
            if (!wdata.mode1)
                mode1 <= 1'b0;
            else if (rw_en)
                mode1 <= 1'b1;
        end
    end

endmodule

// File: rtl/frw_engine.sv
module frw_engine
    import flash_rw_pkg::*;
#(
    parameter int PROG_CYC  = 12,
    parameter int ERASE_CYC = 40,
    parameter int CW        = 6
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_code,
    input  logic          rw_en,
    input  logic          mode1,
    input  logic          pause,
    output op_e           op,
    output logic [CW-1:0] remain,
    output logic          finishing,
    output logic          erase_start,
    output logic          stat_sel
);

    logic accept, prog_start, rdstat_take, run;

    always_comb begin
        accept      = cmd_valid && rw_en && (op == OP_IDLE);
        prog_start  = accept && (cmd_code == CMD_PROG);
        erase_start = accept && (cmd_code == CMD_ERASE);
        rdstat_take = accept && (cmd_code == CMD_RDSTAT) && !mode1;
        run         = (op != OP_IDLE) && !pause;
        finishing   = run && (remain == CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op       <= OP_IDLE;
            remain   <= '0;
            stat_sel <= 1'b0;
        end else begin
            if (prog_start) begin
                op       <= OP_PROG;
                remain   <= CW'(PROG_CYC);
                stat_sel <= 1'b0;
            end else if (erase_start) begin
                op       <= OP_ERASE;
                remain   <= CW'(ERASE_CYC);
                stat_sel <= 1'b0;
            end else if (finishing) begin
                op     <= OP_IDLE;
                remain <= '0;
            end else if (run) begin
                remain <= remain - CW'(1);
            end
            if (rdstat_take)
                stat_sel <= 1'b1;
        end
    end

endmodule

// File: rtl/frw_susp.sv
module frw_susp #(
    parameter int SUSP_LAT = 6,
    parameter int LW       = 3
)(
    input  logic clk,
    input  logic rst,
    input  logic erase_start,
    input  logic susp_en,
    input  logic erase_active,
    input  logic finishing,
    input  logic mode1,
    input  logic irq_req,
    input  logic we,
    input  logic wr_req,
    output logic susp_req
);

    logic          armed;
    logic [LW-1:0] lat;
    logic          can_take, irq_take;

    always_comb begin
        can_take = armed && erase_active && !finishing;
        irq_take = can_take && mode1 && (lat == '0) && !susp_req && irq_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            lat   <= '0;
        end else begin
            if (erase_start)
                armed <= susp_en;
            else if (!erase_active)
                armed <= 1'b0;
            if (erase_start)
                lat <= LW'(SUSP_LAT);
            else if (lat != '0)
                lat <= lat - LW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            susp_req <= 1'b0;
        else if (erase_start)
            susp_req <= 1'b0;
        else if (irq_take)
            susp_req <= 1'b1;
        else if (we)
            susp_req <= wr_req && can_take;
    end

endmodule

// File: rtl/flash_rw_ctrl.sv
module flash_rw_ctrl
    import flash_rw_pkg::*;
#(
    parameter int PROG_CYC  = 12,
    parameter int ERASE_CYC = 40,
    parameter int SUSP_LAT  = 6
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    input  logic       rd_sel,
    output logic [7:0] reg_rdata,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic       irq_req,
    output logic       flash_ready,
    output logic       array_rd_en,
    output logic       stat_path_sel
);

    localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW   = cnt_width(MAXC);
    localparam int LW   = cnt_width(SUSP_LAT);

    ctrl_t         wr_fields;
    logic          rw_en, mode1, susp_en, susp_req;
    op_e           op;
    logic [CW-1:0] remain;
    logic          finishing, erase_start, stat_sel;
    ctrl_t         ctrl_view;
    stat_t         stat_view;

    assign wr_fields = ctrl_t'(ctrl_wdata[3:0]);

    frw_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (ctrl_we),
        .wdata   (wr_fields),
        .ready   (flash_ready),
        .rw_en   (rw_en),
        .mode1   (mode1),
        .susp_en (susp_en)
    );

    frw_engine #(
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC),
        .CW        (CW)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .rw_en       (rw_en),
        .mode1       (mode1),
        .pause       (susp_req),
        .op          (op),
        .remain      (remain),
        .finishing   (finishing),
        .erase_start (erase_start),
        .stat_sel    (stat_sel)
    );

    frw_susp #(
        .SUSP_LAT (SUSP_LAT),
        .LW       (LW)
    ) u_susp (
        .clk          (clk),
        .rst          (rst),
        .erase_start  (erase_start),
        .susp_en      (susp_en),
        .erase_active (op == OP_ERASE),
        .finishing    (finishing),
        .mode1        (mode1),
        .irq_req      (irq_req),
        .we           (ctrl_we),
        .wr_req       (wr_fields.susp_req),
        .susp_req     (susp_req)
    );

    always_comb begin
        flash_ready   = (op == OP_IDLE);
        array_rd_en   = flash_ready || susp_req;
        stat_path_sel = stat_sel;
        ctrl_view     = '{susp_req: susp_req, susp_en: susp_en, mode1: mode1, rw_en: rw_en};
        stat_view     = '{stat_sel: stat_sel, rd_en: array_rd_en, ready: flash_ready};
        reg_rdata     = rd_sel ? pack_stat(stat_view) : pack_ctrl(ctrl_view);
    end

endmodule

// File: rtl/flash_rw_ctrl_chk.sv
module flash_rw_ctrl_chk #(
    parameter int CW = 6
)(
    input logic          clk,
    input logic          rst,
    input logic          ready,
    input logic          rd_en,
    input logic          rw_en,
    input logic          mode1,
    input logic          susp_req,
    input logic          ctrl_we,
    input logic [CW-1:0] remain
);

    assert_rd_off_busy_R13: assert property (@(posedge clk) disable iff (rst)
        (!ready && !susp_req) |-> !rd_en);

    assert_paused_reads_R6: assert property (@(posedge clk) disable iff (rst)
        susp_req |-> (rd_en && !ready));

    assert_count_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        $past(susp_req) && susp_req |-> $stable(remain));

    assert_enable_held_R4: assert property (@(posedge clk) disable iff (rst)
        (rw_en && !ready) |=> rw_en);

    assert_mode_needs_en_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(mode1) |-> $past(rw_en));

    assert_start_needs_en_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(rw_en));

    assert_no_irq_mode0_R10: assert property (@(posedge clk) disable iff (rst)
        ($rose(susp_req) && !$past(mode1)) |-> $past(ctrl_we));

endmodule

bind flash_rw_ctrl flash_rw_ctrl_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ready    (flash_ready),
    .rd_en    (array_rd_en),
    .rw_en    (rw_en),
    .mode1    (mode1),
    .susp_req (susp_req),
    .ctrl_we  (ctrl_we),
    .remain   (remain)
);

// File: tb/flash_rw_ctrl_tb.sv
`timescale 1ns/1ps
module flash_rw_ctrl_tb;
    import flash_rw_pkg::*;

    localparam int PROG  = 12;
    localparam int ERASE = 40;
    localparam int LAT   = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic       rd_sel = 1'b0;
    logic [7:0] reg_rdata;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_code = '0;
    logic       irq_req = 1'b0;
    logic       flash_ready, array_rd_en, stat_path_sel;

    always #10 clk = ~clk;

    flash_rw_ctrl #(.PROG_CYC(PROG), .ERASE_CYC(ERASE), .SUSP_LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .rd_sel(rd_sel), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .irq_req(irq_req), .flash_ready(flash_ready),
        .array_rd_en(array_rd_en), .stat_path_sel(stat_path_sel)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        bit         sel;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;

    task automatic expect_at(int at, bit sel, logic [7:0] v, string req);
        item_t it;
        it.at = at; it.sel = sel; it.exp = v; it.req = req;
        q.push_back(it);
    endtask

    // monitor: pops items due this cycle and compares readback
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].at <= cyc) begin
                    item_t it;
                    it = q[i];
                    q.delete(i);
                    rd_sel = it.sel;
                    #1;
                    checks++;
                    if (it.at < cyc) begin
                        fails++;
                        $display("FAIL %s missed slot at=%0d now=%0d", it.req, it.at, cyc);
                    end else if (reg_rdata !== it.exp) begin
                        fails++;
                        $display("FAIL %s cyc=%0d sel=%0d actual=%02h expected=%02h",
                                 it.req, cyc, it.sel, reg_rdata, it.exp);
                    end
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic cmd(logic [1:0] c);
        cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int k, n, m, r, done;
        tick(3);
        rst = 1'b0;

        // R1 reset values
        k = cyc;
        expect_at(k + 1, 0, 8'h00, "R1");
        expect_at(k + 1, 1, 8'h03, "R1");
        tick(2);

        // R2 commands ignored while disabled
        k = cyc;
        expect_at(k + 1, 1, 8'h03, "R2");
        expect_at(k + 3, 1, 8'h03, "R2");
        expect_at(k + 3, 0, 8'h00, "R2");
        cmd(CMD_PROG); cmd(CMD_ERASE); cmd(CMD_RDSTAT);
        tick(2);

        // R3 mode select needs enable first
        k = cyc;
        expect_at(k + 1, 0, 8'h00, "R3");
        expect_at(k + 2, 0, 8'h01, "R3");
        expect_at(k + 3, 0, 8'h03, "R3");
        wr(8'h02); wr(8'h01); wr(8'h03);
        wr(8'h01);

        // R5 program timing, R4 enable clear while busy, busy command ignored
        n = cyc + 1;
        expect_at(n, 1, 8'h00, "R5");
        expect_at(n + 3, 0, 8'h01, "R4");
        expect_at(n + PROG - 1, 1, 8'h00, "R5");
        expect_at(n + PROG, 1, 8'h03, "R5");
        cmd(CMD_PROG);
        tick(2);
        wr(8'h00);
        cmd(CMD_ERASE);
        tick(n + PROG + 1 - cyc);
        k = cyc;
        expect_at(k + 1, 0, 8'h00, "R4");
        wr(8'h00);
        wr(8'h01);

        // R11 read-status command in mode 0 and mode 1
        k = cyc;
        expect_at(k + 1, 1, 8'h07, "R11");
        cmd(CMD_RDSTAT);
        k = cyc;
        expect_at(k + 1, 1, 8'h00, "R11");
        cmd(CMD_PROG);
        tick(PROG + 1);
        wr(8'h03);
        k = cyc;
        expect_at(k + 2, 1, 8'h03, "R11");
        cmd(CMD_RDSTAT);
        tick(2);
        wr(8'h01);

        // R6 R7 R13 software suspend and resume
        wr(8'h05);
        n = cyc + 1;
        expect_at(n, 1, 8'h00, "R13");
        cmd(CMD_ERASE);
        tick(9);
        m = cyc + 1;
        expect_at(m, 0, 8'h0D, "R6");
        expect_at(m, 1, 8'h02, "R6");
        expect_at(m + 4, 1, 8'h02, "R6");
        wr(8'h0D);
        tick(4);
        r = cyc + 1;
        done = n + ERASE + (r - m);
        expect_at(r, 1, 8'h00, "R7");
        expect_at(done - 1, 1, 8'h00, "R7");
        expect_at(done, 1, 8'h03, "R7");
        wr(8'h05);
        tick(done + 1 - cyc);

        // R8 suspend without arming
        wr(8'h01);
        n = cyc + 1;
        cmd(CMD_ERASE);
        tick(4);
        k = cyc;
        expect_at(k + 1, 0, 8'h01, "R8");
        expect_at(k + 1, 1, 8'h00, "R8");
        expect_at(n + ERASE - 1, 1, 8'h00, "R8");
        expect_at(n + ERASE, 1, 8'h03, "R8");
        wr(8'h09);
        tick(n + ERASE + 1 - cyc);

        // R9 interrupt suspend in mode 1 with latency window
        wr(8'h07);
        n = cyc + 1;
        cmd(CMD_ERASE);
        tick(LAT - 1);
        expect_at(n + LAT, 0, 8'h07, "R9");
        expect_at(n + LAT, 1, 8'h00, "R9");
        expect_at(n + LAT + 1, 0, 8'h0F, "R9");
        expect_at(n + LAT + 1, 1, 8'h02, "R9");
        irq_req = 1'b1;
        tick(2);
        irq_req = 1'b0;
        m = n + LAT + 1;
        tick(5);
        r = cyc + 1;
        done = n + ERASE + (r - m);
        expect_at(done - 1, 1, 8'h00, "R9");
        expect_at(done, 1, 8'h03, "R9");
        wr(8'h07);
        tick(done + 1 - cyc);

        // R10 interrupt ignored in mode 0
        wr(8'h05);
        n = cyc + 1;
        cmd(CMD_ERASE);
        tick(LAT + 2);
        k = cyc;
        expect_at(k + 2, 0, 8'h05, "R10");
        expect_at(k + 2, 1, 8'h00, "R10");
        expect_at(n + ERASE, 1, 8'h03, "R10");
        irq_req = 1'b1;
        tick(1);
        irq_req = 1'b0;
        tick(n + ERASE + 1 - cyc);

        // R12 software request on the final count edge
        n = cyc + 1;
        cmd(CMD_ERASE);
        tick(n + ERASE - 1 - cyc);
        expect_at(n + ERASE, 0, 8'h05, "R12");
        expect_at(n + ERASE, 1, 8'h03, "R12");
        wr(8'h0D);
        tick(2);

        // R12 interrupt on the final count edge
        wr(8'h07);
        n = cyc + 1;
        cmd(CMD_ERASE);
        tick(n + ERASE - 1 - cyc);
        expect_at(n + ERASE, 0, 8'h07, "R12");
        expect_at(n + ERASE, 1, 8'h03, "R12");
        irq_req = 1'b1;
        tick(1);
        irq_req = 1'b0;
        tick(3);

        while (q.size() != 0) tick(1);
        summary();
        $finish;
    end

endmodule